// File: doc/BRIEF.md
# Pixel Matrix Sparsified Readout Controller

This block controls the readout of a pixel matrix built from columns of 16-pixel macro-pixel regions. A behavioural hit array stands in for the analog pixels. Each region latches incoming hit pulses into a 16-bit pattern. Each column raises a fast-OR flag whenever any of its unmasked regions holds a hit.

When a bunch-crossing strobe arrives, the controller freezes every column that currently shows a hit. It then queues one entry for that crossing in a first-in first-out buffer. The entry holds the current time-stamp and a bitmap of the frozen columns.

A sweep engine takes entries from the buffer one at a time. It walks the frozen columns of the entry one by one, in ascending order. For each column it visits the regions and places every non-empty region on a single readout bus as one word. The bus uses a valid/ready handshake. After the last region of a column, the engine clears that column's hits and releases it.

Columns that are not frozen keep collecting hits the whole time. Hits from a later crossing can therefore wait in the matrix while an earlier crossing is still draining. Each crossing comes out tagged with its own time-stamp. Any region can be masked, which silences a noisy or dead region completely.

Top module: `mpx_sparse_rd`

## Requirements
- R1: After reset, `rd_valid` and `ts_ovf` are 0, and the first crossing strobe is tagged with time-stamp 0.
- R2: A strobe freezes every column holding at least one unmasked hit. The hits of that crossing come out as one word per non-empty region, in ascending column order and, within a column, in ascending region order. Each word is `{ts[24:21], col[20:18], region[17:16], pattern[15:0]}`. A region's pattern is the OR of all hit pulses it received before the strobe.
- R3: A region whose bit `reg_mask[col*4+region]` is 1 never produces a word. On its own it does not freeze its column.
- R4: A frozen column ignores new hit pulses until it is released. On release its hits are cleared.
- R5: A column that is not frozen keeps accepting hits while other columns are being read. Those hits come out with the time-stamp of the later crossing.
- R6: The time-stamp advances by one on every strobe, including strobes that freeze nothing or are dropped. It wraps from 15 to 0.
- R7: A strobe that arrives while no unmasked hit is held produces no word.
- R8: A strobe that would freeze columns while the crossing buffer (2 entries) is full is dropped. Its columns stay unfrozen and keep their hits, and `ts_ovf` is set and stays set.
- R9: While `rd_valid` is 1 and `rd_ready` is 0, the word on `rd_data` is held unchanged.
- R10: At most one column is cleared and released in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_in | input | 512 | Hit pulses, 16 bits per region; the region index is col*4+region |
| reg_mask | input | 32 | Per-region mask; 1 silences the region |
| bx_strobe | input | 1 | Bunch-crossing strobe |
| rd_ready | input | 1 | Readout bus ready |
| rd_valid | output | 1 | Readout word valid |
| rd_data | output | 25 | Readout word {ts, col, region, pattern} |
| ts_ovf | output | 1 | Sticky flag: a crossing was dropped because the buffer was full |

## Verification
A hit pulse must be present at a clock edge before the strobe edge to count toward that crossing. At the strobe edge the columns freeze, the entry is queued, the time-stamp steps and the overflow flag may rise. An idle sweep engine loads the entry at the next edge, so the first word can be valid two edges after the strobe edge. Each later word or skipped region costs one edge. The bench drives on falling edges and samples level results such as the overflow flag and the idle bus on the following falling edge. Words themselves are compared by a scoreboard at each handshake, so the checks depend on word order and not on the stall pattern of `rd_ready`.

// File: rtl/mpx_pkg.sv
package mpx_pkg;

    localparam int PIX_W = 16;

    typedef enum logic [0:0] {
        SW_IDLE = 1'b0,
        SW_SCAN = 1'b1
    } sweep_st_e;

endpackage

// File: rtl/mpx_hit_matrix.sv
module mpx_hit_matrix
    import mpx_pkg::*;
#(
    parameter int NCOLS = 8,
    parameter int NREG  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NCOLS*NREG*PIX_W-1:0]   hit_in,
    input  logic [NCOLS*NREG-1:0]         reg_mask,
    input  logic [NCOLS-1:0]              freeze_set,
    input  logic [NCOLS-1:0]              col_clr,
    output logic [NCOLS-1:0]              fast_or,
    output logic [NCOLS-1:0]              frozen,
    output logic [NCOLS*NREG*PIX_W-1:0]   pix_out
);

    localparam int NCELL = NCOLS * NREG;

    typedef struct packed {
        logic [NCOLS-1:0]            frozen;
        logic [NCELL-1:0][PIX_W-1:0] pix;
    } mat_t;

    mat_t mat_d, mat_q;

    always_comb begin
        mat_d = mat_q;
        for (int c = 0; c < NCOLS; c++) begin
            for (int r = 0; r < NREG; r++) begin
                if (col_clr[c]) begin
                    mat_d.pix[c*NREG+r] = '0;
                end else if (!mat_q.frozen[c] && !freeze_set[c]) begin
                    mat_d.pix[c*NREG+r] = mat_q.pix[c*NREG+r]
                        | (hit_in[(c*NREG+r)*PIX_W +: PIX_W]
                           & {PIX_W{~reg_mask[c*NREG+r]}});
                end
            end
            if (col_clr[c]) begin
                mat_d.frozen[c] = 1'b0;
            end else if (freeze_set[c]) begin
                mat_d.frozen[c] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mat_q <= '0;
        end else begin
            mat_q <= mat_d;
        end
    end

    for (genvar gc = 0; gc < NCOLS; gc++) begin : g_col
        logic [NREG-1:0] any_hit;
        for (genvar gr = 0; gr < NREG; gr++) begin : g_reg
            localparam int IDX = gc*NREG + gr;
            assign pix_out[IDX*PIX_W +: PIX_W] =
                mat_q.pix[IDX] & {PIX_W{~reg_mask[IDX]}};
            assign any_hit[gr] = |pix_out[IDX*PIX_W +: PIX_W];
        end
        assign fast_or[gc] = |any_hit;
    end

    assign frozen = mat_q.frozen;

endmodule

// File: rtl/mpx_bx_ctrl.sv
module mpx_bx_ctrl #(
    parameter int NCOLS = 8,
    parameter int TS_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bx_strobe,
    input  logic [NCOLS-1:0] fast_or,
    input  logic [NCOLS-1:0] frozen,
    input  logic             buf_full,
    output logic [NCOLS-1:0] freeze_set,
    output logic             push,
    output logic [TS_W-1:0]  ts_now,
    output logic             ts_ovf
);

    typedef struct packed {
        logic [TS_W-1:0] ts;
        logic            ovf;
    } bx_t;

    bx_t bx_d, bx_q;
    logic [NCOLS-1:0] cand;
    logic             any_cand;

    always_comb begin
        bx_d       = bx_q;
        cand       = fast_or & ~frozen;
        any_cand   = |cand;
        push       = bx_strobe && any_cand && !buf_full;
        freeze_set = push ? cand : '0;
        if (bx_strobe) begin
            bx_d.ts = bx_q.ts + 1'b1;
        end
        if (bx_strobe && any_cand && buf_full) begin
            bx_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bx_q <= '0;
        end else begin
            bx_q <= bx_d;
        end
    end

    assign ts_now = bx_q.ts;
    assign ts_ovf = bx_q.ovf;

endmodule

// File: rtl/mpx_ts_fifo.sv
module mpx_ts_fifo #(
    parameter int DW    = 12,
    parameter int DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          vld,
    output logic          full
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int NW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            wp;
        logic [AW-1:0]            rp;
        logic [NW-1:0]            cnt;
    } fifo_t;

    fifo_t f_d, f_q;
    logic  do_push, do_pop;

    always_comb begin
        f_d     = f_q;
        do_push = push && (f_q.cnt != NW'(DEPTH));
        do_pop  = pop && (f_q.cnt != '0);
        if (do_push) begin
            f_d.mem[f_q.wp] = din;
            f_d.wp = (f_q.wp == AW'(DEPTH-1)) ? '0 : f_q.wp + 1'b1;
        end
        if (do_pop) begin
            f_d.rp = (f_q.rp == AW'(DEPTH-1)) ? '0 : f_q.rp + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   f_d.cnt = f_q.cnt + 1'b1;
            2'b01:   f_d.cnt = f_q.cnt - 1'b1;
            default: f_d.cnt = f_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign dout = f_q.mem[f_q.rp];
    assign vld  = (f_q.cnt != '0);
    assign full = (f_q.cnt == NW'(DEPTH));

endmodule

// File: rtl/mpx_sweep.sv
module mpx_sweep
    import mpx_pkg::*;
#(
    parameter int NCOLS = 8,
    parameter int NREG  = 4,
    parameter int TS_W  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ent_vld,
    input  logic [TS_W-1:0]             ent_ts,
    input  logic [NCOLS-1:0]            ent_map,
    output logic                        pop,
    input  logic [NCOLS*NREG*PIX_W-1:0] pix_in,
    input  logic                        rd_ready,
    output logic                        rd_valid,
    output logic [TS_W+$clog2(NCOLS)+$clog2(NREG)+PIX_W-1:0] rd_data,
    output logic [NCOLS-1:0]            col_clr
);

    localparam int CW = $clog2(NCOLS);
    localparam int RW = $clog2(NREG);

    typedef struct packed {
        sweep_st_e        st;
        logic [NCOLS-1:0] map;
        logic [TS_W-1:0]  ts;
        logic [CW-1:0]    col;
        logic [RW-1:0]    rg;
    } sw_t;

    sw_t sw_d, sw_q;
    logic [PIX_W-1:0] cur;
    logic [NCOLS-1:0] rest;

    function automatic logic [CW-1:0] lowest(input logic [NCOLS-1:0] m);
        logic [CW-1:0] idx;
        idx = '0;
        for (int i = NCOLS-1; i >= 0; i--) begin
            if (m[i]) idx = CW'(i);
        end
        return idx;
    endfunction

    always_comb begin
        sw_d     = sw_q;
        pop      = 1'b0;
        col_clr  = '0;
        rest     = sw_q.map & ~(NCOLS'(1) << sw_q.col);
        cur      = pix_in[(int'(sw_q.col)*NREG + int'(sw_q.rg))*PIX_W +: PIX_W];
        rd_valid = (sw_q.st == SW_SCAN) && (cur != '0);
        rd_data  = {sw_q.ts, sw_q.col, sw_q.rg, cur};
        case (sw_q.st)
            SW_IDLE: begin
                if (ent_vld) begin
                    pop       = 1'b1;
                    sw_d.map  = ent_map;
                    sw_d.ts   = ent_ts;
                    sw_d.col  = lowest(ent_map);
                    sw_d.rg   = '0;
                    sw_d.st   = SW_SCAN;
                end
            end
            SW_SCAN: begin
                if ((cur == '0) || rd_ready) begin
                    if (sw_q.rg == RW'(NREG-1)) begin
                        col_clr[sw_q.col] = 1'b1;
                        sw_d.map = rest;
                        sw_d.col = lowest(rest);
                        sw_d.rg  = '0;
                        if (rest == '0) begin
                            sw_d.st = SW_IDLE;
                        end
                    end else begin
                        sw_d.rg = sw_q.rg + 1'b1;
                    end
                end
            end
            default: sw_d.st = SW_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_q <= '0;
        end else begin
            sw_q <= sw_d;
        end
    end

endmodule

// File: rtl/mpx_sparse_rd.sv
module mpx_sparse_rd
    import mpx_pkg::*;
#(
    parameter int NCOLS      = 8,
    parameter int NREG       = 4,
    parameter int TS_W       = 4,
    parameter int FIFO_DEPTH = 2
) (
    input  logic                                              clk,
    input  logic                                              rst_n,
    input  logic [NCOLS*NREG*16-1:0]                          hit_in,
    input  logic [NCOLS*NREG-1:0]                             reg_mask,
    input  logic                                              bx_strobe,
    input  logic                                              rd_ready,
    output logic                                              rd_valid,
    output logic [TS_W+$clog2(NCOLS)+$clog2(NREG)+16-1:0]     rd_data,
    output logic                                              ts_ovf
);

    localparam int ENT_W = TS_W + NCOLS;

    logic [NCOLS-1:0]            fast_or;
    logic [NCOLS-1:0]            frozen;
    logic [NCOLS-1:0]            freeze_set;
    logic [NCOLS-1:0]            col_clr;
    logic [NCOLS*NREG*PIX_W-1:0] pix_bus;
    logic                        push;
    logic                        pop;
    logic                        buf_full;
    logic                        ent_vld;
    logic [ENT_W-1:0]            ent;
    logic [TS_W-1:0]             ts_now;

    mpx_hit_matrix #(.NCOLS(NCOLS), .NREG(NREG)) u_matrix (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_in     (hit_in),
        .reg_mask   (reg_mask),
        .freeze_set (freeze_set),
        .col_clr    (col_clr),
        .fast_or    (fast_or),
        .frozen     (frozen),
        .pix_out    (pix_bus)
    );

    mpx_bx_ctrl #(.NCOLS(NCOLS), .TS_W(TS_W)) u_bx (
        .clk        (clk),
        .rst_n      (rst_n),
        .bx_strobe  (bx_strobe),
        .fast_or    (fast_or),
        .frozen     (frozen),
        .buf_full   (buf_full),
        .freeze_set (freeze_set),
        .push       (push),
        .ts_now     (ts_now),
        .ts_ovf     (ts_ovf)
    );

    mpx_ts_fifo #(.DW(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   ({ts_now, freeze_set}),
        .pop   (pop),
        .dout  (ent),
        .vld   (ent_vld),
        .full  (buf_full)
    );

    mpx_sweep #(.NCOLS(NCOLS), .NREG(NREG), .TS_W(TS_W)) u_sweep (
        .clk      (clk),
        .rst_n    (rst_n),
        .ent_vld  (ent_vld),
        .ent_ts   (ent[ENT_W-1 -: TS_W]),
        .ent_map  (ent[NCOLS-1:0]),
        .pop      (pop),
        .pix_in   (pix_bus),
        .rd_ready (rd_ready),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .col_clr  (col_clr)
    );

endmodule

// File: rtl/mpx_sparse_rd_chk.sv
module mpx_sparse_rd_chk #(
    parameter int NCOLS = 8,
    parameter int NREG  = 4,
    parameter int TS_W  = 4
) (
    input logic                                          clk,
    input logic                                          rst_n,
    input logic                                          bx_strobe,
    input logic                                          rd_valid,
    input logic                                          rd_ready,
    input logic [TS_W+$clog2(NCOLS)+$clog2(NREG)+16-1:0] rd_data,
    input logic                                          ts_ovf,
    input logic [NCOLS*NREG-1:0]                         reg_mask,
    input logic [NCOLS-1:0]                              col_clr,
    input logic [TS_W-1:0]                               ts_now
);

    localparam int CW = $clog2(NCOLS);
    localparam int RW = $clog2(NREG);

    logic [CW-1:0] w_col;
    logic [RW-1:0] w_rg;
    assign w_col = rd_data[16+RW +: CW];
    assign w_rg  = rd_data[16 +: RW];

    // R9
    hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ts_ovf |=> ts_ovf);

    // R10
    one_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(col_clr));

    // R2
    nonempty_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_data[15:0] != 16'h0));

    // R6
    ts_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bx_strobe |=> ts_now == TS_W'($past(ts_now) + 1'b1));

    // R3
    masked_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !reg_mask[int'(w_col)*NREG + int'(w_rg)]);

endmodule

bind mpx_sparse_rd mpx_sparse_rd_chk #(.NCOLS(NCOLS), .NREG(NREG), .TS_W(TS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bx_strobe (bx_strobe),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_data   (rd_data),
    .ts_ovf    (ts_ovf),
    .reg_mask  (reg_mask),
    .col_clr   (col_clr),
    .ts_now    (ts_now)
);

// File: tb/mpx_sparse_rd_tb.sv
`timescale 1ns/1ps
module mpx_sparse_rd_tb;

    localparam int NC = 8;
    localparam int NR = 4;
    localparam int WW = 25;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [511:0]   hit_in = '0;
    logic [31:0]    reg_mask = '0;
    logic           bx_strobe = 1'b0;
    logic           rd_ready = 1'b0;
    logic           rd_valid;
    logic [WW-1:0]  rd_data;
    logic           ts_ovf;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic [3:0] exp_ts = 4'd0;
    logic [WW-1:0] exp_q[$];
    logic hold_off = 1'b1;
    logic jitter = 1'b0;
    logic [7:0] lfsr = 8'h5a;
    logic prev_stall = 1'b0;
    logic [WW-1:0] prev_word = '0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    mpx_sparse_rd u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_in    (hit_in),
        .reg_mask  (reg_mask),
        .bx_strobe (bx_strobe),
        .rd_ready  (rd_ready),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .ts_ovf    (ts_ovf)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic expect_word(input int c, input int r, input logic [15:0] p);
        exp_q.push_back({exp_ts, 3'(c), 2'(r), p});
    endtask

    task automatic hit(input int c, input int r, input logic [15:0] p);
        @(negedge clk);
        hit_in[(c*NR+r)*16 +: 16] = p;
        @(negedge clk);
        hit_in = '0;
    endtask

    task automatic strobe();
        @(negedge clk);
        bx_strobe = 1'b1;
        @(negedge clk);
        bx_strobe = 1'b0;
        exp_ts = exp_ts + 1'b1;
    endtask

    task automatic drain(input string req);
        int n;
        n = 0;
        while (exp_q.size() != 0 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        repeat (6) @(negedge clk);
        chk(exp_q.size() == 0 && !rd_valid, req, 32'(exp_q.size()), 32'd0);
    endtask

    task automatic quiet(input string req);
        logic seen;
        seen = 1'b0;
        repeat (10) begin
            @(negedge clk);
            if (rd_valid) seen = 1'b1;
        end
        chk(!seen, req, 32'(seen), 32'd0);
    endtask

    // ready driver: changes 2 ns after each rising edge
    always @(posedge clk) begin
        #2;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        rd_ready = hold_off ? 1'b0 : (jitter ? lfsr[0] : 1'b1);
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) begin
                // R9 word held while stalled
                chk(rd_valid && rd_data == prev_word, "R9", 32'(rd_data), 32'(prev_word));
            end
            prev_stall = rd_valid && !rd_ready;
            prev_word  = rd_data;
            if (rd_valid && rd_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected word", 32'(rd_data), 32'd0);
                end else begin
                    logic [WW-1:0] e;
                    e = exp_q.pop_front();
                    // R2 word order and content
                    chk(rd_data == e, "R2", 32'(rd_data), 32'(e));
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        reg_mask = 32'h0;
        reg_mask[1*NR+2] = 1'b1;
        reg_mask[6*NR+2] = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!rd_valid, "R1 valid", 32'(rd_valid), 32'd0);
        chk(!ts_ovf, "R1 ovf", 32'(ts_ovf), 32'd0);

        // R2 R1: basic crossing, ts 0, jittered ready, accumulated hits
        hold_off = 1'b0;
        jitter = 1'b1;
        hit(5, 0, 16'h8000);
        hit(2, 1, 16'h00A5);
        hit(5, 3, 16'h0100);
        hit(5, 0, 16'h0001);
        expect_word(2, 1, 16'h00A5);
        expect_word(5, 0, 16'h8001);
        expect_word(5, 3, 16'h0100);
        strobe();
        drain("R2 drain");

        // R7 R4: empty strobe, released columns were cleared
        strobe();
        quiet("R7");

        // R3: masked regions silent, masked-only column not frozen
        hit(1, 2, 16'hFFFF);
        hit(1, 0, 16'h0003);
        hit(6, 2, 16'h0F0F);
        expect_word(1, 0, 16'h0003);
        strobe();
        drain("R3");

        // R4 R5 R8: overlapping crossings with stalled bus
        jitter = 1'b0;
        hold_off = 1'b1;
        hit(0, 0, 16'h1111);
        expect_word(0, 0, 16'h1111);
        strobe();                       // ts3, col0 frozen and loaded
        hit(0, 1, 16'h2222);            // R4 ignored, col0 frozen
        hit(4, 2, 16'h4444);            // R5 accepted
        expect_word(4, 2, 16'h4444);
        strobe();                       // ts4
        hit(7, 3, 16'h7777);
        expect_word(7, 3, 16'h7777);
        strobe();                       // ts5, buffer now full
        chk(!ts_ovf, "R8 no ovf yet", 32'(ts_ovf), 32'd0);
        hit(3, 0, 16'h3333);
        strobe();                       // ts6 dropped
        chk(ts_ovf, "R8 ovf set", 32'(ts_ovf), 32'd1);
        hold_off = 1'b0;
        drain("R5 drain");
        expect_word(3, 0, 16'h3333);    // R8 hits kept
        strobe();                       // ts7
        drain("R8 kept hits");
        chk(ts_ovf, "R8 sticky", 32'(ts_ovf), 32'd1);
        quiet("R4 ignored hit");

        // R6: wrap of the time-stamp
        repeat (8) strobe();            // ts8..ts15
        chk(exp_ts == 4'd0, "R6 bench ts", 32'(exp_ts), 32'd0);
        hit(2, 2, 16'hBEEF);
        expect_word(2, 2, 16'hBEEF);
        strobe();                       // tagged 0
        drain("R6 wrap");

        // R10: two columns read back to back
        hit(6, 1, 16'h0006);
        hit(7, 0, 16'h0007);
        expect_word(6, 1, 16'h0006);
        expect_word(7, 0, 16'h0007);
        strobe();
        drain("R10");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule